// File: doc/BRIEF.md
# Pulse-Frequency Burst Gate Controller

This block sequences the two power switches of a synchronous step-down stage in pulse-frequency mode. Two external comparators report whether the output has sagged below its target and whether the inductor current has fallen to zero or below. Both arrive as raw single-bit flags. The block passes each one through a multi-flop synchronizer, then runs a short, fixed energy burst whenever the undervoltage flag rises. It idles with both switches open for the rest of the time.

A burst has three phases. First the high-side PMOS conducts for a fixed on-time; its gate is active low. Then both devices are held off for a break-before-make interval. Then the low-side NMOS conducts until the zero-current flag arrives. A cycle counter bounds the low-side phase, so a flag that never arrives cannot leave the NMOS on. The on-time is given in nanoseconds together with the clock rate in MHz, and the block rounds it up to whole cycles. At 100 MHz the 300 ns default gives 30 cycles. A two-bit status output reports the current phase.

Top module: `pfm_gate_ctrl`

## Requirements
- R1: When reset is asserted (active low, asynchronous), `hs_gate_n` goes to 1 and `ls_gate` to 0 and `phase` reads 0, with no clock edge needed. This holds even if reset interrupts a burst.
- R2: A burst starts only from idle, and only on a 0-to-1 change of the synchronized undervoltage flag. If `uv_raw` rises while the clock is low, `phase` becomes 1 and `hs_gate_n` becomes 0 after the third rising clock edge.
- R3: The high-side phase (`phase`=1, `hs_gate_n`=0) lasts exactly ON_CYC cycles, where ON_CYC = ceil(ON_NS*CLK_MHZ/1000). With the defaults that is 30 cycles.
- R4: The high-side phase is always followed by a dead phase (`phase`=2) of exactly DEAD_CYC cycles, during which both gates are in their off state.
- R5: The dead phase is followed by the low-side phase (`phase`=3, `ls_gate`=1). If `izc_raw` rises while the clock is low, `ls_gate` returns to 0 and `phase` to 0 after the third rising edge. The low-side phase therefore spans d+3 cycles when the flag rises d cycles after the phase is first seen.
- R6: If the zero-current flag has not ended it earlier, the low-side phase ends after LS_MAX_CYC cycles. The controller then returns to idle with the NMOS off.
- R7: `hs_gate_n`=0 and `ls_gate`=1 never occur in the same cycle.
- R8: An undervoltage flag that stays high after a burst does not start another one. A fall and rise of the flag during a burst is ignored.
- R9: `phase` is encoded as 0 idle, 1 high-side on, 2 dead, 3 low-side on. In idle both gates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uv_raw | input | 1 | Unsynchronized undervoltage comparator flag (1 = feedback below reference) |
| izc_raw | input | 1 | Unsynchronized zero/negative inductor-current flag |
| hs_gate_n | output | 1 | High-side PMOS gate, 0 = conducting |
| ls_gate | output | 1 | Low-side NMOS gate, 1 = conducting |
| phase | output | 2 | Current phase: 0 idle, 1 high-side, 2 dead, 3 low-side |

## Verification
The hardest case to reach from the ports is a low-side phase where the zero-current flag arrives exactly at the timeout. Here both exit causes fall in the same cycle, and the phase length must stay at LS_MAX_CYC. Just below that point, the flag must still win by one cycle. The stimulus waits until `phase` first shows the low-side value and then delays `izc_raw` by a chosen count. Directed bursts use delays of 0, LS_MAX_CYC-4, LS_MAX_CYC-3 and well beyond the limit, and random bursts spread the delay over the whole range. During bursts the undervoltage flag is held high or toggled, to confirm that the trigger is ignored there.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_DEAD = 2'd2,
        PH_LOW  = 2'd3
    } phase_e;

endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;

        if (g == 0) begin : g_first
            assign stage_d = din;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_d;
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pfm_rise.sv
module pfm_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise = level & ~prev_q;

endmodule

// File: rtl/pfm_fsm.sv
module pfm_fsm
    import pfm_pkg::*;
#(
    parameter int ON_CYC     = 30,
    parameter int DEAD_CYC   = 3,
    parameter int LS_MAX_CYC = 100
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   trig,
    input  logic   zc,
    output logic   hs_gate_n,
    output logic   ls_gate,
    output phase_e phase
);

    localparam int CNT_MAX = (ON_CYC > DEAD_CYC)
                           ? ((ON_CYC > LS_MAX_CYC) ? ON_CYC : LS_MAX_CYC)
                           : ((DEAD_CYC > LS_MAX_CYC) ? DEAD_CYC : LS_MAX_CYC);
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] ON_LOAD   = CNT_W'(ON_CYC - 1);
    localparam logic [CNT_W-1:0] DEAD_LOAD = CNT_W'(DEAD_CYC - 1);
    localparam logic [CNT_W-1:0] LS_LOAD   = CNT_W'(LS_MAX_CYC - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             hs_n;
        logic             ls;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (trig) begin
                    ctl_d.phase = PH_HIGH;
                    ctl_d.cnt   = ON_LOAD;
                end
            end
            PH_HIGH: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.phase = PH_DEAD;
                    ctl_d.cnt   = DEAD_LOAD;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_DEAD: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.phase = PH_LOW;
                    ctl_d.cnt   = LS_LOAD;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_LOW: begin
                if (zc || ctl_q.cnt == '0) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.cnt   = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: begin
                ctl_d.phase = PH_IDLE;
                ctl_d.cnt   = '0;
            end
        endcase
        // Gates registered from the next phase so they move with it.
        ctl_d.hs_n = (ctl_d.phase != PH_HIGH);
        ctl_d.ls   = (ctl_d.phase == PH_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.phase <= PH_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.hs_n  <= 1'b1;
            ctl_q.ls    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign hs_gate_n = ctl_q.hs_n;
    assign ls_gate   = ctl_q.ls;
    assign phase     = ctl_q.phase;

endmodule

// File: rtl/pfm_gate_ctrl.sv
module pfm_gate_ctrl
    import pfm_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int ON_NS       = 300,
    parameter int DEAD_CYC    = 3,
    parameter int LS_MAX_CYC  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_raw,
    input  logic       izc_raw,
    output logic       hs_gate_n,
    output logic       ls_gate,
    output logic [1:0] phase
);

    localparam int ON_RAW = (ON_NS * CLK_MHZ + 999) / 1000;
    localparam int ON_CYC = (ON_RAW < 1) ? 1 : ON_RAW;

    logic [1:0] flags_s;
    logic       uv_rise;
    phase_e     phase_w;

    pfm_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({izc_raw, uv_raw}),
        .dout  (flags_s)
    );

    pfm_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (flags_s[0]),
        .rise  (uv_rise)
    );

    pfm_fsm #(
        .ON_CYC     (ON_CYC),
        .DEAD_CYC   (DEAD_CYC),
        .LS_MAX_CYC (LS_MAX_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (uv_rise),
        .zc        (flags_s[1]),
        .hs_gate_n (hs_gate_n),
        .ls_gate   (ls_gate),
        .phase     (phase_w)
    );

    assign phase = phase_w;

endmodule

// File: rtl/pfm_gate_ctrl_chk.sv
module pfm_gate_ctrl_chk #(
    parameter int ON_CYC     = 30,
    parameter int DEAD_CYC   = 3,
    parameter int LS_MAX_CYC = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_gate_n,
    input logic       ls_gate,
    input logic [1:0] phase
);

    logic [1:0]  prev_ph;
    int unsigned run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ph <= 2'd0;
            run     <= 0;
        end else begin
            prev_ph <= phase;
            run     <= (phase != prev_ph) ? 1 : run + 1;
        end
    end

    assert_reset_safe_R1: assert property (@(posedge clk)
        !rst_n |-> (hs_gate_n && !ls_gate && phase == 2'd0));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!hs_gate_n && ls_gate));

    assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ph == 2'd0 && phase != 2'd0) |-> phase == 2'd1);

    assert_hs_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ph == 2'd1 && phase != 2'd1) |-> (run == ON_CYC && phase == 2'd2));

    assert_dead_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ph == 2'd2 && phase != 2'd2) |-> (run == DEAD_CYC && phase == 2'd3));

    assert_ls_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ph == 2'd3 && phase != 2'd3) |-> phase == 2'd0);

    assert_ls_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ph == 2'd3 && phase == 2'd3) |-> run < LS_MAX_CYC);

    assert_gate_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_gate_n == (phase != 2'd1)) && (ls_gate == (phase == 2'd3)));

endmodule

bind pfm_gate_ctrl pfm_gate_ctrl_chk #(
    .ON_CYC     (ON_CYC),
    .DEAD_CYC   (DEAD_CYC),
    .LS_MAX_CYC (LS_MAX_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_gate_n (hs_gate_n),
    .ls_gate   (ls_gate),
    .phase     (phase)
);

// File: tb/pfm_gate_ctrl_test.sv
`timescale 1ns/1ps
module pfm_gate_ctrl_test;

    localparam int ON_CYC   = 30;
    localparam int DEAD_CYC = 3;
    localparam int LS_MAX   = 100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       uv_raw;
    logic       izc_raw;
    logic       hs_gate_n;
    logic       ls_gate;
    logic [1:0] phase;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pfm_gate_ctrl #(
        .CLK_MHZ     (100),
        .ON_NS       (300),
        .DEAD_CYC    (DEAD_CYC),
        .LS_MAX_CYC  (LS_MAX),
        .SYNC_STAGES (2)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .uv_raw    (uv_raw),
        .izc_raw   (izc_raw),
        .hs_gate_n (hs_gate_n),
        .ls_gate   (ls_gate),
        .phase     (phase)
    );

    function automatic int exp_ls_len(int d);
        return (d + 3 < LS_MAX) ? d + 3 : LS_MAX;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One burst; called at a negedge with both flags low and the block idle.
    task automatic run_burst(int d, int uv_hold, bit glitch);
        int samples = 0, hs = 0, dd = 0, ls = 0;
        int first_hs = -1, ls_seen = -1, overlap = 0, map_err = 0, after = 0;
        bit ended = 0;
        uv_raw = 1'b1;
        for (int it = 0; it < 400; it++) begin
            @(posedge clk);
            @(negedge clk);
            samples++;
            if (!hs_gate_n && ls_gate) overlap++;
            if (hs_gate_n != (phase != 2'd1) || ls_gate != (phase == 2'd3)) map_err++;
            if (ended) begin
                if (phase != 2'd0) after++;
                if (samples >= ended_at(ls_seen, ls) + 10) break;
            end else begin
                case (phase)
                    2'd1: begin hs++; if (first_hs < 0) first_hs = samples; end
                    2'd2: dd++;
                    2'd3: begin ls++; if (ls_seen < 0) ls_seen = samples; end
                    default: if (ls_seen > 0) ended = 1;
                endcase
            end
            if (samples == uv_hold) uv_raw = 1'b0;
            if (glitch && samples == 10) uv_raw = 1'b0;
            if (glitch && samples == 14) uv_raw = 1'b1;
            if (ls_seen > 0 && samples == ls_seen + d) izc_raw = 1'b1;
        end
        check(first_hs == 3, "R2 burst start latency", first_hs, 3);
        check(hs == ON_CYC, "R3 high-side length", hs, ON_CYC);
        check(dd == DEAD_CYC, "R4 dead length", dd, DEAD_CYC);
        check(ls == exp_ls_len(d), "R5/R6 low-side length", ls, exp_ls_len(d));
        check(overlap == 0, "R7 overlap cycles", overlap, 0);
        check(map_err == 0, "R9 gate/phase mismatches", map_err, 0);
        check(ended && after == 0, "R8 no retrigger cycles", after, 0);
        uv_raw  = 1'b0;
        izc_raw = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    function automatic int ended_at(int s0, int n);
        return s0 + n;
    endfunction

    initial begin
        #1500000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n   = 1'b1;
        uv_raw  = 1'b0;
        izc_raw = 1'b0;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(hs_gate_n == 1'b1, "R1 hs_gate_n in reset", int'(hs_gate_n), 1);
        check(ls_gate == 1'b0, "R1 ls_gate in reset", int'(ls_gate), 0);
        check(phase == 2'd0, "R1 phase in reset", int'(phase), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(phase == 2'd0, "R9 idle after reset", int'(phase), 0);

        // Directed corners around the low-side timeout
        run_burst(0, 5, 1'b0);
        run_burst(LS_MAX - 4, 300, 1'b0);
        run_burst(LS_MAX - 3, 2, 1'b1);
        run_burst(LS_MAX + 20, 300, 1'b1);

        // Random bursts
        for (int n = 0; n < 30; n++) begin
            int d  = int'($urandom_range(LS_MAX + 10, 0));
            int uh = int'($urandom_range(250, 2));
            bit gl = 1'($urandom_range(1, 0));
            run_burst(d, uh, gl);
        end

        // R1: reset in the middle of the high-side phase
        uv_raw = 1'b1;
        repeat (8) @(negedge clk);
        check(phase == 2'd1, "R2 in high-side before reset", int'(phase), 1);
        uv_raw = 1'b0;
        rst_n  = 1'b0;
        #1;
        check(hs_gate_n == 1'b1 && ls_gate == 1'b0, "R1 async reset mid-burst",
              int'({hs_gate_n, ls_gate}), 2);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(phase == 2'd0, "R1 idle after mid-burst reset", int'(phase), 0);
        run_burst(7, 20, 1'b0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule